// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Column Driver Core

This block is the logic core of a display column driver. A serial bit stream is clocked into a chain of stages, one bit per rising clock edge. Each stage feeds one hold stage and one output channel. A direction input chooses which way bits travel through the chain. It also chooses which of the two shared data pins accepts serial input and which of them drives the cascade output to the next device in a chain of drivers.

A hold bank sits between the chain and the outputs. While the hold enable is high, the bank passes the chain contents straight through. While it is low, the bank keeps the value captured at the last rising edge that saw the enable high. A final stage applies a two-input control table to every channel at once: all channels high, all channels low, data passed through, or data inverted.

Each shared data pin is modelled as a separate input, output and output-enable signal. An asynchronous active-low reset clears the chain and the hold bank to zero.

Top module: `col_drv_core`

## Requirements
- R1: While rst_ni is low, every chain stage and every hold stage is cleared to zero.
- R2: When dir_i is 1, each rising edge moves stage k to stage k+1, and pin_a_i enters stage 0. Stage k drives chan_o[k].
- R3: When dir_i is 0, each rising edge moves stage k to stage k-1, and pin_b_i enters stage N_STAGES-1.
- R4: pin_b_oe_o equals dir_i and pin_a_oe_o equals the inverse of dir_i, so exactly one pin drives at any time.
- R5: pin_b_o always shows stage N_STAGES-1 and pin_a_o always shows stage 0. The pin that is enabled is therefore the last stage in the active direction.
- R6: hold_en_i, blank_ni and pol_i have no effect on how the chain shifts.
- R7: While hold_en_i is 1, the hold bank follows the chain. While hold_en_i is 0, the bank keeps the chain value that followed the last rising edge at which hold_en_i was 1.
- R8: With blank_ni=0, every channel reads 1 when pol_i=0 and every channel reads 0 when pol_i=1.
- R9: With blank_ni=1, chan_o equals the held data when pol_i=1 and its bitwise inverse when pol_i=0.
- R10: A change of dir_i between edges leaves the chain contents untouched. The new direction applies from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 1: shift up, input on pin A; 0: shift down, input on pin B |
| hold_en_i | input | 1 | Hold bank transparent when 1, holding when 0 |
| blank_ni | input | 1 | 0 forces all channels to the level chosen by pol_i |
| pol_i | input | 1 | Polarity select |
| pin_a_i | input | 1 | Pin A input side |
| pin_a_o | output | 1 | Pin A output side (stage 0) |
| pin_a_oe_o | output | 1 | Pin A output enable |
| pin_b_i | input | 1 | Pin B input side |
| pin_b_o | output | 1 | Pin B output side (stage N_STAGES-1) |
| pin_b_oe_o | output | 1 | Pin B output enable |
| chan_o | output | N_STAGES | Channel outputs, bit k from stage k |

## Verification
The bench builds the block with its default of 64 stages, the full width of a real column. Within a short run this lets a pattern fill the whole chain in each direction and run past the far end. Both cascade pins are then observed carrying data that has travelled the full length, rather than only the first few stages. Because the channel vector is 64 bits wide, the bench also compares all four blank and polarity encodings against a held pattern that differs from the live chain.

// File: rtl/col_drv_pkg.sv
`timescale 1ns/1ps
package col_drv_pkg;
  // Output mode, indexed by {blank_ni, pol_i}
  typedef enum logic [1:0] {
    MODE_ALL_HI = 2'b00,
    MODE_ALL_LO = 2'b01,
    MODE_INVERT = 2'b10,
    MODE_PASS   = 2'b11
  } out_mode_e;
endpackage

// File: rtl/col_drv_shifter.sv
`timescale 1ns/1ps
module col_drv_shifter #(
  parameter int N_STAGES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dir_i,
  input  logic                ser_up_i,
  input  logic                ser_dn_i,
  output logic [N_STAGES-1:0] sr_q_o,
  output logic [N_STAGES-1:0] sr_d_o
);
  localparam int LAST = N_STAGES - 1;

  logic [N_STAGES-1:0] sr_q;
  logic [N_STAGES-1:0] sr_d;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    logic from_lo, from_hi;
    if (g == 0) begin : g_first
      assign from_lo = ser_up_i;
    end else begin : g_mid_lo
      assign from_lo = sr_q[g-1];
    end
    if (g == LAST) begin : g_last
      assign from_hi = ser_dn_i;
    end else begin : g_mid_hi
      assign from_hi = sr_q[g+1];
    end
    assign sr_d[g] = dir_i ? from_lo : from_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sr_q_o = sr_q;
  assign sr_d_o = sr_d;
endmodule

// File: rtl/col_drv_hold.sv
`timescale 1ns/1ps
module col_drv_hold #(
  parameter int N_STAGES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [N_STAGES-1:0] sr_q_i,
  input  logic [N_STAGES-1:0] sr_d_i,
  output logic [N_STAGES-1:0] hold_o
);
  logic [N_STAGES-1:0] held_q;

  // Capture the post-edge chain value so a later enable drop keeps it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (en_i) held_q <= sr_d_i;
  end

  // Transparent path while enabled
  assign hold_o = en_i ? sr_q_i : held_q;
endmodule

// File: rtl/col_drv_outmux.sv
`timescale 1ns/1ps
module col_drv_outmux
  import col_drv_pkg::*;
#(
  parameter int N_STAGES = 64
) (
  input  logic                blank_ni,
  input  logic                pol_i,
  input  logic [N_STAGES-1:0] data_i,
  output logic [N_STAGES-1:0] chan_o
);
  out_mode_e mode;
  assign mode = out_mode_e'({blank_ni, pol_i});

  for (genvar g = 0; g < N_STAGES; g++) begin : g_ch
    always_comb begin
      unique case (mode)
        MODE_ALL_HI: chan_o[g] = 1'b1;
        MODE_ALL_LO: chan_o[g] = 1'b0;
        MODE_INVERT: chan_o[g] = ~data_i[g];
        default:     chan_o[g] = data_i[g];
      endcase
    end
  end
endmodule

// File: rtl/col_drv_core.sv
`timescale 1ns/1ps
module col_drv_core #(
  parameter int N_STAGES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dir_i,
  input  logic                hold_en_i,
  input  logic                blank_ni,
  input  logic                pol_i,
  input  logic                pin_a_i,
  output logic                pin_a_o,
  output logic                pin_a_oe_o,
  input  logic                pin_b_i,
  output logic                pin_b_o,
  output logic                pin_b_oe_o,
  output logic [N_STAGES-1:0] chan_o
);
  localparam int LAST = N_STAGES - 1;

  logic [N_STAGES-1:0] sr_q, sr_d, hold;

  col_drv_shifter #(.N_STAGES(N_STAGES)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_i    (dir_i),
    .ser_up_i (pin_a_i),
    .ser_dn_i (pin_b_i),
    .sr_q_o   (sr_q),
    .sr_d_o   (sr_d)
  );

  col_drv_hold #(.N_STAGES(N_STAGES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (hold_en_i),
    .sr_q_i (sr_q),
    .sr_d_i (sr_d),
    .hold_o (hold)
  );

  col_drv_outmux #(.N_STAGES(N_STAGES)) u_out (
    .blank_ni (blank_ni),
    .pol_i    (pol_i),
    .data_i   (hold),
    .chan_o   (chan_o)
  );

  // Cascade: far end in each direction
  assign pin_a_o    = sr_q[0];
  assign pin_b_o    = sr_q[LAST];
  assign pin_a_oe_o = ~dir_i;
  assign pin_b_oe_o = dir_i;
endmodule

// File: rtl/col_drv_chk.sv
`timescale 1ns/1ps
module col_drv_chk #(
  parameter int N_STAGES = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                dir_i,
  input logic                hold_en_i,
  input logic                blank_ni,
  input logic                pol_i,
  input logic                pin_a_i,
  input logic                pin_b_i,
  input logic                pin_a_o,
  input logic                pin_b_o,
  input logic                pin_a_oe_o,
  input logic                pin_b_oe_o,
  input logic [N_STAGES-1:0] sr_q,
  input logic [N_STAGES-1:0] hold,
  input logic [N_STAGES-1:0] chan_o
);
  localparam int LAST = N_STAGES - 1;

  always_comb begin
    if (rst_ni) begin
      p_one_driver_r4: assert ($onehot({pin_a_oe_o, pin_b_oe_o}) && (pin_b_oe_o == dir_i))
        else $error("R4 pin enable");
    end
  end

  p_shift_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i |=> (sr_q[0] == $past(pin_a_i)) && (sr_q[LAST:1] == $past(sr_q[LAST-1:0])));

  p_shift_dn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_i |=> (sr_q[LAST] == $past(pin_b_i)) && (sr_q[LAST-1:0] == $past(sr_q[LAST:1])));

  p_cascade_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dir_i) |-> pin_b_o == $past(sr_q[LAST-1]));

  p_cascade_dn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dir_i) |-> pin_a_o == $past(sr_q[1]));

  p_hold_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_en_i && $past(!hold_en_i)) |-> $stable(hold));

  p_force_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_ni && !pol_i) |-> (&chan_o));

  p_force_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_ni && pol_i) |-> (chan_o == '0));

  p_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && pol_i && hold_en_i) |-> (chan_o == sr_q));

  p_invert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && !pol_i && hold_en_i) |-> (chan_o == ~sr_q));
endmodule

bind col_drv_core col_drv_chk #(.N_STAGES(N_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dir_i      (dir_i),
  .hold_en_i  (hold_en_i),
  .blank_ni   (blank_ni),
  .pol_i      (pol_i),
  .pin_a_i    (pin_a_i),
  .pin_b_i    (pin_b_i),
  .pin_a_o    (pin_a_o),
  .pin_b_o    (pin_b_o),
  .pin_a_oe_o (pin_a_oe_o),
  .pin_b_oe_o (pin_b_oe_o),
  .sr_q       (sr_q),
  .hold       (hold),
  .chan_o     (chan_o)
);

// File: tb/col_drv_core_test.sv
`timescale 1ns/1ps
module col_drv_core_test;
  localparam int N = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, dir = 1'b1, hen = 1'b0, bl_n = 1'b1, pol = 1'b1;
  logic pa = 1'b0, pb = 1'b0;
  logic pa_o, pa_oe, pb_o, pb_oe;
  logic [N-1:0] chan;

  col_drv_core #(.N_STAGES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .hold_en_i(hen),
    .blank_ni(bl_n), .pol_i(pol),
    .pin_a_i(pa), .pin_a_o(pa_o), .pin_a_oe_o(pa_oe),
    .pin_b_i(pb), .pin_b_o(pb_o), .pin_b_oe_o(pb_oe),
    .chan_o(chan)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] m_sr = '0, m_lat = '0;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_chan();
    logic [N-1:0] v;
    v = hen ? m_sr : m_lat;
    case ({bl_n, pol})
      2'b00:   return '1;
      2'b01:   return '0;
      2'b10:   return ~v;
      default: return v;
    endcase
  endfunction

  function automatic logic pat(input int i, input int s);
    return ((i * 13 + s * 7) % 11) < 5;
  endfunction

  // Drive at negedge, model the edge, return at next negedge
  task automatic step(input logic d, input logic a, input logic b);
    dir = d; pa = a; pb = b;
    @(posedge clk);
    if (d) m_sr = {m_sr[N-2:0], a};
    else   m_sr = {b, m_sr[N-1:1]};
    if (hen) m_lat = m_sr;
    @(negedge clk);
  endtask

  task automatic chk_pins(input string req);
    chk({req, " pin_a_o"}, N'(pa_o), N'(m_sr[0]));
    chk({req, " pin_b_o"}, N'(pb_o), N'(m_sr[N-1]));
  endtask

  task automatic t_reset();
    hen = 1'b1; bl_n = 1'b1; pol = 1'b1;
    repeat (3) @(negedge clk);
    // Run past reset with data on both pins; nothing must load
    pa = 1'b1; pb = 1'b1;
    @(negedge clk);
    chk("R1 chain clear", chan, '0);
    rst_n = 1'b1; hen = 1'b0; pa = 1'b0; pb = 1'b0;
    #1;
    chk("R1 hold clear", chan, '0);
    chk_pins("R1");
  endtask

  task automatic t_forward();
    hen = 1'b1; bl_n = 1'b1; pol = 1'b1;
    for (int i = 0; i < N + 6; i++) begin
      step(1'b1, pat(i, 1), ~pat(i, 1));
      if (i % 16 == 5) begin
        chk("R2 shift up", chan, exp_chan());
        chk_pins("R5 up");
        chk("R4 oe up", N'({pa_oe, pb_oe}), N'(2'b01));
      end
    end
    chk("R2 full fill", chan, exp_chan());
  endtask

  task automatic t_reverse();
    hen = 1'b1;
    for (int i = 0; i < N + 5; i++) begin
      step(1'b0, ~pat(i, 2), pat(i, 3));
      if (i % 16 == 7) begin
        chk("R3 shift down", chan, exp_chan());
        chk_pins("R5 down");
        chk("R4 oe down", N'({pa_oe, pb_oe}), N'(2'b10));
      end
    end
    chk("R3 full fill", chan, exp_chan());
  endtask

  task automatic t_hold();
    hen = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, pat(i, 4), 1'b0);
    hen = 1'b0;
    for (int i = 0; i < 12; i++) step(1'b1, ~pat(i, 5), 1'b1);
    chk("R7 held value", chan, exp_chan());
    chk("R7 held differs", N'(m_lat != m_sr), N'(1));
    hen = 1'b1;
    #1;
    chk("R7 transparent", chan, m_sr);
  endtask

  task automatic t_ctrl_ignored();
    for (int i = 0; i < 24; i++) begin
      hen = pat(i, 6); bl_n = pat(i, 7); pol = pat(i, 8);
      step(i % 3 != 0, pat(i, 9), ~pat(i, 9));
    end
    hen = 1'b1; bl_n = 1'b1; pol = 1'b1;
    #1;
    chk("R6 chain unaffected", chan, m_sr);
    chk_pins("R6");
  endtask

  task automatic t_blank_pol();
    hen = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b1, pat(i, 10), 1'b0);
    hen = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
    bl_n = 1'b0; pol = 1'b0; #1; chk("R8 all high", chan, '1);
    bl_n = 1'b0; pol = 1'b1; #1; chk("R8 all low", chan, '0);
    bl_n = 1'b1; pol = 1'b1; #1; chk("R9 pass", chan, m_lat);
    bl_n = 1'b1; pol = 1'b0; #1; chk("R9 invert", chan, ~m_lat);
    pol = 1'b1;
  endtask

  task automatic t_dir_switch();
    logic [N-1:0] snap;
    hen = 1'b1; bl_n = 1'b1; pol = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b1, pat(i, 11), 1'b0);
    snap = m_sr;
    dir = 1'b0;
    #3;
    chk("R10 no change between edges", chan, snap);
    chk("R4 oe swap", N'({pa_oe, pb_oe}), N'(2'b10));
    step(1'b0, 1'b0, 1'b1);
    chk("R10 new dir at edge", chan, exp_chan());
    chk_pins("R10");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_ctrl_ignored();
    t_blank_pol();
    t_dir_switch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule